// File: doc/BRIEF.md
# Register-Staged Memory Access Unit

This block is a small word-addressed storage array that a controller can reach only through three holding registers. An address register (MAR) latches the cell number. A data register (MDR) receives words that are read out. An accumulator supplies the words that are written. Each request runs as a short, fixed sequence. The address is captured, it is decoded into a one-hot cell select that is held in a register, and then the selected cell is either copied into the MDR or overwritten with the accumulator value.

The accumulator has its own load strobe and can be updated at any time. A store takes a private copy of the accumulator when the request is accepted. A build parameter chooses the decoder. In the flat form, one select line is driven per address value. In the grid form, the upper address bits drive row lines, the lower bits drive column lines, and a cell is selected only where its row line and its column line cross. The default build has 4 cells of 16 bits behind a 2-bit MAR.

Top module: `staged_mem_unit`

## Requirements
- R1: While reset is high at a clock edge, the MAR, MDR and accumulator are cleared to zero on that edge, and busy and done read 0 afterwards. The array contents are not initialised.
- R2: A request with `req_valid` high in an idle cycle is accepted on that edge. `done` is high in the cycle that follows the third edge counted from acceptance. For a fetch, `mdr_q` holds the word of the addressed cell in that same cycle.
- R3: A fetch does not alter the cell it reads. Fetching the same address twice returns the same word.
- R4: A store writes the accepted accumulator copy into the addressed cell and replaces whatever the cell held before.
- R5: During a fetch or a store, no cell changes other than the one addressed by a store.
- R6: `acc_ld` loads `acc_din` into the accumulator on the next edge, whatever state the sequence is in. A store uses the accumulator value from its acceptance edge, so a later load does not change what it writes.
- R7: While busy, any new request is ignored. The MAR keeps the accepted address, and no extra done pulse or write follows.
- R8: `busy` is high for exactly the two cycles after acceptance, and `done` is a single-cycle pulse.
- R9: The flat decoder raises exactly one select line, line k for MAR value k. For the default 2-bit MAR this gives d0 = ~a&~b, d1 = ~a&b, d2 = a&~b and d3 = a&b, with a as the MSB.
- R10: In grid mode, the row index is the upper half of the MAR and the column index is the lower half. Cell row*2^colbits+col is selected, so address k reaches the same cell in both decoder modes.
- R11: From the cycle after acceptance until the next acceptance, `mar_q` shows the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_ld | input | 1 | Load strobe for the accumulator |
| acc_din | input | DATA_W | Word loaded into the accumulator |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | ADDR_W | Cell address for the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mar_q | output | ADDR_W | Address register contents |
| mdr_q | output | DATA_W | Data register contents |
| acc_q | output | DATA_W | Accumulator contents |

## Verification
The hardest cases to provoke from the ports are the two that rely on timing in the middle of a sequence. One is a stray request that arrives while busy. The other is an accumulator load that lands between the acceptance of a store and its write. The driver raises a conflicting store to the neighbouring address across both busy cycles, and separately reloads the accumulator in the decode cycle of a store. It then fetches the neighbour cell and the stored cell, so that any wrongly accepted write or late sample shows up in the data. Every cell is filled with a distinct word and read back through a flat and a grid instance side by side, which also exposes any decoder that picks the wrong cell or more than one cell.

// File: rtl/smu_pkg.sv
package smu_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DECODE = 2'd1,
    SEQ_ACCESS = 2'd2
  } seq_state_e;
endpackage

// File: rtl/smu_decode.sv
module smu_decode #(
  parameter int ADDR_W = 2,
  parameter bit GRID   = 1'b0,
  localparam int CELLS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CELLS-1:0]  sel
);
  generate
    if (GRID) begin : g_grid
      localparam int COL_W = ADDR_W / 2;
      localparam int ROW_W = ADDR_W - COL_W;
      localparam int ROWS  = 1 << ROW_W;
      localparam int COLS  = 1 << COL_W;
      logic [ROWS-1:0] row_line;
      logic [COLS-1:0] col_line;
      always_comb begin
        for (int r = 0; r < ROWS; r++)
          row_line[r] = (addr[ADDR_W-1:COL_W] == ROW_W'(r));
        for (int c = 0; c < COLS; c++)
          col_line[c] = (addr[COL_W-1:0] == COL_W'(c));
      end
      for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
          assign sel[r*COLS + c] = row_line[r] & col_line[c];
        end
      end
    end else begin : g_flat
      always_comb begin
        for (int k = 0; k < CELLS; k++)
          sel[k] = (addr == ADDR_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/smu_cells.sv
module smu_cells #(
  parameter int DATA_W = 16,
  parameter int CELLS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CELLS-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [CELLS];

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      always_ff @(posedge clk) begin
        if (wr_en && sel[i]) mem[i] <= wdata;
      end

      // R5
      cell_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel[i]) |=> (mem[i] === $past(mem[i])))
        else $error("cell %0d changed without its write", i);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CELLS; i++)
      rdata = rdata | (mem[i] & {DATA_W{sel[i]}});
  end
endmodule

// File: rtl/smu_seq.sv
module smu_seq
  import smu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output seq_state_e state,
  output logic       accept,
  output logic       busy,
  output logic       done
);
  assign accept = (state == SEQ_IDLE) && req_valid;
  assign busy   = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == SEQ_ACCESS);
      unique case (state)
        SEQ_IDLE:   if (req_valid) state <= SEQ_DECODE;
        SEQ_DECODE: state <= SEQ_ACCESS;
        SEQ_ACCESS: state <= SEQ_IDLE;
        default:    state <= SEQ_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done held longer than one cycle");

  // R2
  access_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ACCESS) |=> (done && !busy)) else $error("done missing after access");
endmodule

// File: rtl/staged_mem_unit.sv
module staged_mem_unit
  import smu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter bit GRID   = 1'b0,
  localparam int CELLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_ld,
  input  logic [DATA_W-1:0] acc_din,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] acc_q
);
  seq_state_e        state;
  logic              accept;
  logic              op_wr;
  logic [DATA_W-1:0] st_data;
  logic [CELLS-1:0]  dec_sel;
  logic [CELLS-1:0]  sel_q;
  logic [DATA_W-1:0] rdata;
  logic              wr_en;

  smu_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .state     (state),
    .accept    (accept),
    .busy      (busy),
    .done      (done)
  );

  smu_decode #(.ADDR_W(ADDR_W), .GRID(GRID)) u_dec (
    .addr (mar_q),
    .sel  (dec_sel)
  );

  assign wr_en = (state == SEQ_ACCESS) && op_wr;

  smu_cells #(.DATA_W(DATA_W), .CELLS(CELLS)) u_cells (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .sel   (sel_q),
    .wdata (st_data),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q   <= '0;
      mdr_q   <= '0;
      acc_q   <= '0;
      st_data <= '0;
      op_wr   <= 1'b0;
      sel_q   <= '0;
    end else begin
      if (acc_ld) acc_q <= acc_din;
      if (accept) begin
        mar_q   <= req_addr;
        op_wr   <= req_write;
        st_data <= acc_q;
      end
      if (state == SEQ_DECODE) sel_q <= dec_sel;
      if (state == SEQ_ACCESS && !op_wr) mdr_q <= rdata;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mar_q == '0 && mdr_q == '0 && acc_q == '0 && !busy && !done))
    else $error("registers not cleared by reset");

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ACCESS) |-> ($countones(sel_q) == 1))
    else $error("cell select not one-hot");

  // R7
  mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mar_q)) else $error("MAR moved while busy");

  // R6
  store_copy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st_data)) else $error("store word moved while busy");
endmodule

// File: tb/staged_mem_unit_tb.sv
module staged_mem_unit_tb;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NC = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_ld = 1'b0;
  logic [DW-1:0] acc_din = '0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;

  logic busy_a, done_a, busy_b, done_b;
  logic [AW-1:0] mar_a, mar_b;
  logic [DW-1:0] mdr_a, mdr_b, acc_a, acc_b;

  always #10 clk = ~clk;

  staged_mem_unit #(.DATA_W(DW), .ADDR_W(AW), .GRID(1'b0)) u_dut (
    .clk(clk), .rst(rst), .acc_ld(acc_ld), .acc_din(acc_din),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .busy(busy_a), .done(done_a), .mar_q(mar_a), .mdr_q(mdr_a), .acc_q(acc_a));

  staged_mem_unit #(.DATA_W(DW), .ADDR_W(AW), .GRID(1'b1)) u_dut_2d (
    .clk(clk), .rst(rst), .acc_ld(acc_ld), .acc_din(acc_din),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .busy(busy_b), .done(done_b), .mar_q(mar_b), .mdr_q(mdr_b), .acc_q(acc_b));

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] ref_mem [NC];
  logic [DW-1:0] acc_ref = '0;
  logic [DW:0] sb_q [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp);
    chk({req, " flat"}, a, exp);
    chk({req, " grid"}, b, exp);
  endtask

  // scoreboard monitor: pops one item per done pulse
  always @(negedge clk) begin
    if (!rst && (done_a || done_b)) begin
      if (sb_q.size() == 0) begin
        chk("R7 unexpected done", 32'(done_a | done_b), 32'd0);
      end else begin
        logic [DW:0] it;
        it = sb_q.pop_front();
        chk_both("R8 done both", 32'(done_a), 32'(done_b), 32'd1);
        if (it[DW]) chk_both("R2 R10 fetch data", 32'(mdr_a), 32'(mdr_b), 32'(it[DW-1:0]));
      end
    end
  end

  task automatic load_acc(input logic [DW-1:0] v);
    @(negedge clk);
    acc_ld = 1'b1; acc_din = v;
    @(negedge clk);
    acc_ld = 1'b0;
    acc_ref = v;
    chk_both("R6 acc load", 32'(acc_a), 32'(acc_b), 32'(v));
  endtask

  task automatic run_op(input logic wr, input logic [AW-1:0] ad,
                        input bit inject, input bit chg, input logic [DW-1:0] nv);
    @(negedge clk);
    chk_both("R8 idle before", 32'(busy_a), 32'(busy_b), 32'd0);
    req_valid = 1'b1; req_write = wr; req_addr = ad;
    if (wr) begin
      ref_mem[ad] = acc_ref;
      sb_q.push_back({1'b0, acc_ref});
    end else begin
      sb_q.push_back({1'b1, ref_mem[ad]});
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk_both("R8 busy c1", 32'(busy_a), 32'(busy_b), 32'd1);
    chk_both("R11 mar", 32'(mar_a), 32'(mar_b), 32'(ad));
    if (inject) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = ad ^ 1;
    end
    if (chg) begin
      acc_ld = 1'b1; acc_din = nv; acc_ref = nv;
    end
    @(negedge clk);
    acc_ld = 1'b0;
    chk_both("R8 busy c2", 32'(busy_a), 32'(busy_b), 32'd1);
    chk_both("R8 no early done", 32'(done_a), 32'(done_b), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk_both("R2 done at third cycle", 32'(done_a), 32'(done_b), 32'd1);
    chk_both("R7 mar kept", 32'(mar_a), 32'(mar_b), 32'(ad));
    @(negedge clk);
    chk_both("R8 done one cycle", 32'(done_a), 32'(done_b), 32'd0);
    chk_both("R7 stray not taken", 32'(busy_a), 32'(busy_b), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk_both("R1 mar clear", 32'(mar_a), 32'(mar_b), 32'd0);
    chk_both("R1 mdr clear", 32'(mdr_a), 32'(mdr_b), 32'd0);
    chk_both("R1 acc clear", 32'(acc_a), 32'(acc_b), 32'd0);
    chk_both("R1 busy clear", 32'(busy_a), 32'(busy_b), 32'd0);
    rst = 1'b0;

    // R4 R9 R10: distinct word in every cell, then read all back
    for (int k = 0; k < NC; k++) begin
      load_acc(16'hA000 + 16'(k * 16'h0111));
      run_op(1'b1, AW'(k), 1'b0, 1'b0, '0);
    end
    for (int k = 0; k < NC; k++) run_op(1'b0, AW'(k), 1'b0, 1'b0, '0);

    // R3 repeated fetch
    run_op(1'b0, 4'd5, 1'b0, 1'b0, '0);
    run_op(1'b0, 4'd5, 1'b0, 1'b0, '0);

    // R4 R5 overwrite and neighbours
    load_acc(16'hBEEF);
    run_op(1'b1, 4'd3, 1'b0, 1'b0, '0);
    run_op(1'b0, 4'd3, 1'b0, 1'b0, '0);
    run_op(1'b0, 4'd2, 1'b0, 1'b0, '0);
    run_op(1'b0, 4'd4, 1'b0, 1'b0, '0);

    // R7 stray store during a fetch and during a store
    run_op(1'b0, 4'd7, 1'b1, 1'b0, '0);
    run_op(1'b0, 4'd6, 1'b0, 1'b0, '0);
    load_acc(16'h0F0F);
    run_op(1'b1, 4'd10, 1'b1, 1'b0, '0);
    run_op(1'b0, 4'd11, 1'b0, 1'b0, '0);
    run_op(1'b0, 4'd10, 1'b0, 1'b0, '0);

    // R6 accumulator reload mid-store
    load_acc(16'h1234);
    run_op(1'b1, 4'd9, 1'b0, 1'b1, 16'h5678);
    run_op(1'b0, 4'd9, 1'b0, 1'b0, '0);
    chk_both("R6 acc after reload", 32'(acc_a), 32'(acc_b), 32'h5678);

    // R5 full sweep after all activity
    for (int k = 0; k < NC; k++) run_op(1'b0, AW'(k), 1'b0, 1'b0, '0);

    chk("R7 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule